// File: doc/BRIEF.md
# Four-Pointer Descriptor Ring Tracker

This block keeps the bookkeeping for a circular ring of buffer descriptors. The ring has `DEPTH` entries, and each descriptor index stands for one fixed, equal-sized data buffer slot. Four ring indices chase each other around the ring. Software owns two of them and moves them with register writes: a release index and a post (doorbell) index. Hardware owns the other two: a fetch index and a completion index. The same logic serves a transmit ring and a receive ring without change. Only the meaning of a region differs. On transmit, a fetched entry holds a filled packet. On receive, a fetched entry offers an empty buffer.

The chase order is post index, then fetch index, then completion index, then release index, then back to the post index. Each index may advance only up to the index ahead of it. The gap between two neighbouring indices forms a region, and the occupancy of each region is reported. One slot is always held back, so a full ring and an empty ring can never be mistaken for each other. The DMA engine takes descriptors through a fetch handshake and hands them back through a completion handshake. The interrupt stays high while completed entries wait for software. A per-region stall timer marks the stage that stops moving.

Top module: `desc_ring_tracker`

## Requirements
- R1: After reset, all four indices are 0, the free count is DEPTH-1, the other three counts are 0, and `irq`, `wr_err`, `stuck`, `fetch_valid` and `cmpl_valid` are all 0.
- R2: The region counts are computed modulo DEPTH, and together they always add up to DEPTH-1:
  - free = release - post - 1
  - posted = post - fetch
  - inflight = fetch - completion
  - done = completion - release
- R3: A write with select 0 sets the post index to `sw_wr_data[IDX_W-1:0]` when the forward distance from the old post index is no larger than the free count. The new value shows at the ports after the clock edge.
- R4: A post or release write that would move past the index ahead of it is rejected. The index stays unchanged and the sticky `wr_err` bit is set. A write with select 3 and data bit 4 set clears `wr_err`.
- R5: `fetch_valid` is 1 exactly when the posted count is nonzero, and `fetch_idx` shows the fetch index. `fetch_take` advances the fetch index by one (mod DEPTH) only while `fetch_valid` is 1, and is ignored otherwise.
- R6: `cmpl_valid` is 1 exactly when the inflight count is nonzero, and `cmpl_idx` shows the completion index. `cmpl_take` advances the completion index by one only while `cmpl_valid` is 1, and is ignored otherwise.
- R7: A write with select 1 sets the release index to the written value when the forward distance is no larger than the done count.
- R8: `irq` is 1 exactly while the done count is nonzero. It is therefore high in the cycle after any accepted completion, and it drops once software releases up to the completion index.
- R9: A write with select 2 sets the stall timeout T. For region i, the stuck bits are indexed in this order: bit 0 free, bit 1 posted, bit 2 inflight, bit 3 done. When region i has been nonempty with no advance of its consuming index for T consecutive clock edges, and it is still stalled at the next edge, `stuck[i]` is set at that edge. T = 0 disables the timer.
- R10: A write with select 3 clears the stuck bits selected by `sw_wr_data[3:0]`. If the set condition holds at the same edge, the set wins.
- R11: All index arithmetic wraps modulo DEPTH, so any number of laps around the ring keeps the counts and handshakes correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_wr_en | input | 1 | Register write strobe |
| sw_wr_sel | input | 2 | Register select: 0 post, 1 release, 2 timeout, 3 clear |
| sw_wr_data | input | DATA_W | Write data |
| fetch_valid | output | 1 | A posted descriptor is available |
| fetch_idx | output | IDX_W | Index of the next descriptor to fetch |
| fetch_take | input | 1 | Fetch stage takes the descriptor |
| cmpl_valid | output | 1 | A descriptor is in flight |
| cmpl_idx | output | IDX_W | Index of the next descriptor to complete |
| cmpl_take | input | 1 | Completion stage retires the descriptor |
| irq | output | 1 | Completed descriptors wait for software |
| sw_get_ptr | output | IDX_W | Release index |
| sw_put_ptr | output | IDX_W | Post index |
| hw_get_ptr | output | IDX_W | Fetch index |
| hw_put_ptr | output | IDX_W | Completion index |
| free_cnt | output | IDX_W | Entries free for software to post |
| posted_cnt | output | IDX_W | Entries posted, not yet fetched |
| inflight_cnt | output | IDX_W | Entries fetched, not yet completed |
| done_cnt | output | IDX_W | Entries completed, not yet released |
| stuck | output | 4 | Per-region stall flags |
| wr_err | output | 1 | Sticky rejected-write flag |

## Verification
The hardest situation to reach from the ports is a stuck flag being set at the same edge as its clear. This needs a region held stalled for exactly T+1 edges, with a saturated stall counter, and only then a clear write. The bench gets there from a fresh reset. It programs a small timeout, posts a few descriptors, and then counts idle cycles to the edge so that the set and the clear meet. A long pseudo-random walk of posts, fetches, completions and releases covers the rest: legal and illegal distances, takes ignored on empty regions, and many laps of wrap. A simple arithmetic model of the four indices checks every port after each step.

// File: rtl/ring_trk_pkg.sv
package ring_trk_pkg;
  typedef enum logic [1:0] {
    SEL_POST    = 2'd0,
    SEL_RELEASE = 2'd1,
    SEL_TIMEOUT = 2'd2,
    SEL_CLEAR   = 2'd3
  } wr_sel_e;

  localparam int unsigned NREG         = 4;
  localparam int unsigned REG_FREE     = 0;
  localparam int unsigned REG_POSTED   = 1;
  localparam int unsigned REG_INFLIGHT = 2;
  localparam int unsigned REG_DONE     = 3;
  localparam int unsigned ERR_CLR_BIT  = 4;
endpackage

// File: rtl/ring_ptr_ctrl.sv
module ring_ptr_ctrl
  import ring_trk_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fetch_take,
  input  logic              cmpl_take,
  output logic [IDX_W-1:0]  rel_idx,
  output logic [IDX_W-1:0]  post_idx,
  output logic [IDX_W-1:0]  fch_idx,
  output logic [IDX_W-1:0]  cpl_idx,
  output logic [IDX_W-1:0]  c_free,
  output logic [IDX_W-1:0]  c_posted,
  output logic [IDX_W-1:0]  c_inflight,
  output logic [IDX_W-1:0]  c_done,
  output logic [NREG-1:0]   adv,
  output logic              err
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);
  localparam int unsigned SUM_W = IDX_W + 2;

  wr_sel_e sel;
  logic [IDX_W-1:0] rel_q, rel_d, post_q, post_d, fch_q, fch_d, cpl_q, cpl_d;
  logic err_q, err_d;
  logic [IDX_W-1:0] req_idx, post_dist, rel_dist;
  logic post_wr, rel_wr, post_ok, rel_ok, fetch_go, cmpl_go;

  assign sel        = wr_sel_e'(wr_sel);
  assign req_idx    = wr_data[IDX_W-1:0];
  assign c_free     = rel_q - post_q - ONE;
  assign c_posted   = post_q - fch_q;
  assign c_inflight = fch_q - cpl_q;
  assign c_done     = cpl_q - rel_q;
  assign post_dist  = req_idx - post_q;
  assign rel_dist   = req_idx - rel_q;
  assign post_wr    = wr_en && (sel == SEL_POST);
  assign rel_wr     = wr_en && (sel == SEL_RELEASE);
  assign post_ok    = post_dist <= c_free;
  assign rel_ok     = rel_dist <= c_done;
  assign fetch_go   = fetch_take && (c_posted != '0);
  assign cmpl_go    = cmpl_take && (c_inflight != '0);

  always_comb begin
    post_d = post_q;
    rel_d  = rel_q;
    fch_d  = fch_q;
    cpl_d  = cpl_q;
    err_d  = err_q;
    if (wr_en && (sel == SEL_CLEAR) && wr_data[ERR_CLR_BIT]) err_d = 1'b0;
    if (post_wr) begin
      if (post_ok) post_d = req_idx;
      else         err_d  = 1'b1;
    end
    if (rel_wr) begin
      if (rel_ok) rel_d = req_idx;
      else        err_d = 1'b1;
    end
    if (fetch_go) fch_d = fch_q + ONE;
    if (cmpl_go)  cpl_d = cpl_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_q  <= '0;
      post_q <= '0;
      fch_q  <= '0;
      cpl_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (post_wr || rel_wr || fetch_go || cmpl_go) begin
        rel_q  <= rel_d;
        post_q <= post_d;
        fch_q  <= fch_d;
        cpl_q  <= cpl_d;
      end
      err_q <= err_d;
    end
  end

  assign adv[REG_FREE]     = post_wr && post_ok && (post_dist != '0);
  assign adv[REG_POSTED]   = fetch_go;
  assign adv[REG_INFLIGHT] = cmpl_go;
  assign adv[REG_DONE]     = rel_wr && rel_ok && (rel_dist != '0);

  assign rel_idx  = rel_q;
  assign post_idx = post_q;
  assign fch_idx  = fch_q;
  assign cpl_idx  = cpl_q;
  assign err      = err_q;

  // R2: the four regions always partition DEPTH-1 entries
  assert_region_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (SUM_W'(c_free) + SUM_W'(c_posted) + SUM_W'(c_inflight) + SUM_W'(c_done))
      == SUM_W'(DEPTH - 1));

  // R5: a take with nothing posted leaves the fetch index alone
  assert_fetch_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_take && (c_posted == '0)) |=> $stable(fch_q));

  // R6: a take with nothing in flight leaves the completion index alone
  assert_cmpl_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_take && (c_inflight == '0)) |=> $stable(cpl_q));

  // R4: an overreaching post write is refused and flagged
  assert_bad_post_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (post_wr && !post_ok) |=> (err_q && $stable(post_q)));
endmodule

// File: rtl/ring_stall_timer.sv
module ring_stall_timer #(
  parameter int unsigned TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busy,
  input  logic             adv,
  input  logic [TMR_W-1:0] timeout,
  input  logic             clr,
  output logic             stuck
);
  logic             stall, hit, set;
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             stuck_q, stuck_d;

  assign stall = busy && !adv;
  assign hit   = cnt_q >= timeout;
  assign set   = stall && hit && (timeout != '0);

  always_comb begin
    if (!stall)   cnt_d = '0;
    else if (hit) cnt_d = cnt_q;
    else          cnt_d = cnt_q + TMR_W'(1);
    stuck_d = set | (stuck_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      stuck_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stuck_q <= stuck_d;
    end
  end

  assign stuck = stuck_q;

  // R9: with the timer disabled a clear flag never comes up
  assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((timeout == '0) && !stuck_q) |=> !stuck_q);

  // R9: a flag only rises after a stalled cycle
  assert_rise_needs_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stuck_q) |-> $past(stall));
endmodule

// File: rtl/desc_ring_tracker.sv
module desc_ring_tracker
  import ring_trk_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sw_wr_en,
  input  logic [1:0]               sw_wr_sel,
  input  logic [DATA_W-1:0]        sw_wr_data,
  output logic                     fetch_valid,
  output logic [$clog2(DEPTH)-1:0] fetch_idx,
  input  logic                     fetch_take,
  output logic                     cmpl_valid,
  output logic [$clog2(DEPTH)-1:0] cmpl_idx,
  input  logic                     cmpl_take,
  output logic                     irq,
  output logic [$clog2(DEPTH)-1:0] sw_get_ptr,
  output logic [$clog2(DEPTH)-1:0] sw_put_ptr,
  output logic [$clog2(DEPTH)-1:0] hw_get_ptr,
  output logic [$clog2(DEPTH)-1:0] hw_put_ptr,
  output logic [$clog2(DEPTH)-1:0] free_cnt,
  output logic [$clog2(DEPTH)-1:0] posted_cnt,
  output logic [$clog2(DEPTH)-1:0] inflight_cnt,
  output logic [$clog2(DEPTH)-1:0] done_cnt,
  output logic [3:0]               stuck,
  output logic                     wr_err
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  c_free, c_posted, c_inflight, c_done;
  logic [NREG-1:0]   adv, busy, clr;
  logic [NREG-1:0]   stuck_v;
  logic [DATA_W-1:0] tmo_q, tmo_d;
  logic              tmo_we, clr_we;

  ring_ptr_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (sw_wr_en),
    .wr_sel     (sw_wr_sel),
    .wr_data    (sw_wr_data),
    .fetch_take (fetch_take),
    .cmpl_take  (cmpl_take),
    .rel_idx    (sw_get_ptr),
    .post_idx   (sw_put_ptr),
    .fch_idx    (hw_get_ptr),
    .cpl_idx    (hw_put_ptr),
    .c_free     (c_free),
    .c_posted   (c_posted),
    .c_inflight (c_inflight),
    .c_done     (c_done),
    .adv        (adv),
    .err        (wr_err)
  );

  assign tmo_we = sw_wr_en && (wr_sel_e'(sw_wr_sel) == SEL_TIMEOUT);
  assign clr_we = sw_wr_en && (wr_sel_e'(sw_wr_sel) == SEL_CLEAR);
  assign tmo_d  = sw_wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tmo_q <= '0;
    else if (tmo_we) tmo_q <= tmo_d;
  end

  assign busy[REG_FREE]     = c_free != '0;
  assign busy[REG_POSTED]   = c_posted != '0;
  assign busy[REG_INFLIGHT] = c_inflight != '0;
  assign busy[REG_DONE]     = c_done != '0;

  for (genvar i = 0; i < NREG; i++) begin : g_tmr
    assign clr[i] = clr_we && sw_wr_data[i];
    ring_stall_timer #(.TMR_W(DATA_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .busy    (busy[i]),
      .adv     (adv[i]),
      .timeout (tmo_q),
      .clr     (clr[i]),
      .stuck   (stuck_v[i])
    );
  end

  assign stuck        = stuck_v;
  assign fetch_valid  = busy[REG_POSTED];
  assign fetch_idx    = hw_get_ptr;
  assign cmpl_valid   = busy[REG_INFLIGHT];
  assign cmpl_idx     = hw_put_ptr;
  assign irq          = busy[REG_DONE];
  assign free_cnt     = c_free;
  assign posted_cnt   = c_posted;
  assign inflight_cnt = c_inflight;
  assign done_cnt     = c_done;

  // R8: an accepted completion leaves an interrupt pending
  assert_irq_after_cmpl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_take && cmpl_valid) |=> irq);
endmodule

// File: tb/tb_desc_ring_tracker.sv
module tb_desc_ring_tracker;
  localparam int N = 8;
  localparam int M = N - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [1:0]  sw_wr_sel = 2'd0;
  logic [15:0] sw_wr_data = 16'd0;
  logic        fetch_take = 1'b0;
  logic        cmpl_take = 1'b0;
  logic        fetch_valid, cmpl_valid, irq, wr_err;
  logic [2:0]  fetch_idx, cmpl_idx, sw_get_ptr, sw_put_ptr, hw_get_ptr, hw_put_ptr;
  logic [2:0]  free_cnt, posted_cnt, inflight_cnt, done_cnt;
  logic [3:0]  stuck;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int m_sg, m_sp, m_hg, m_hp, m_err;
  int unsigned lcg = 32'h1234_5678;

  always #10 clk = ~clk;

  desc_ring_tracker #(.DEPTH(N), .DATA_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel),
    .sw_wr_data(sw_wr_data), .fetch_valid(fetch_valid), .fetch_idx(fetch_idx),
    .fetch_take(fetch_take), .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx),
    .cmpl_take(cmpl_take), .irq(irq), .sw_get_ptr(sw_get_ptr),
    .sw_put_ptr(sw_put_ptr), .hw_get_ptr(hw_get_ptr), .hw_put_ptr(hw_put_ptr),
    .free_cnt(free_cnt), .posted_cnt(posted_cnt), .inflight_cnt(inflight_cnt),
    .done_cnt(done_cnt), .stuck(stuck), .wr_err(wr_err)
  );

  function automatic int fr();  return (m_sg - m_sp - 1) & M; endfunction
  function automatic int po();  return (m_sp - m_hg) & M; endfunction
  function automatic int inf(); return (m_hg - m_hp) & M; endfunction
  function automatic int dn();  return (m_hp - m_sg) & M; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit en, input int sel, input int data, input bit ft, input bit ct);
    @(negedge clk);
    sw_wr_en = en; sw_wr_sel = 2'(sel); sw_wr_data = 16'(data);
    fetch_take = ft; cmpl_take = ct;
    @(posedge clk);
    #5;
    sw_wr_en = 1'b0; fetch_take = 1'b0; cmpl_take = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_sg = 0; m_sp = 0; m_hg = 0; m_hp = 0; m_err = 0;
  endtask

  task automatic check_all(input int st_exp);
    chk(sw_get_ptr == 3'(m_sg), "R7 release index", sw_get_ptr, m_sg);
    chk(sw_put_ptr == 3'(m_sp), "R3 post index", sw_put_ptr, m_sp);
    chk(hw_get_ptr == 3'(m_hg) && fetch_idx == 3'(m_hg), "R5 fetch index", hw_get_ptr, m_hg);
    chk(hw_put_ptr == 3'(m_hp) && cmpl_idx == 3'(m_hp), "R6 completion index", hw_put_ptr, m_hp);
    chk(free_cnt == 3'(fr()) && posted_cnt == 3'(po()), "R2 free/posted counts",
        {free_cnt, posted_cnt}, (fr() << 3) | po());
    chk(inflight_cnt == 3'(inf()) && done_cnt == 3'(dn()), "R2 inflight/done counts",
        {inflight_cnt, done_cnt}, (inf() << 3) | dn());
    chk(fetch_valid == (po() != 0) && cmpl_valid == (inf() != 0), "R5 R6 valids",
        {fetch_valid, cmpl_valid}, {po() != 0, inf() != 0});
    chk(irq == (dn() != 0), "R8 irq", irq, dn() != 0);
    chk(wr_err == m_err[0], "R4 wr_err", wr_err, m_err);
    chk(stuck == 4'(st_exp), "R9 stuck", stuck, st_exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R1: reset state
    check_all(0);
    chk(free_cnt == 3'(M), "R1 free after reset", free_cnt, M);

    // R3 R4 R5 R6 R7 R8 R11: pseudo-random walk with many laps
    for (int s = 0; s < 3000; s++) begin
      int op, k, f0, p0, i0, d0;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      op = int'((lcg >> 16) & 7);
      k  = int'((lcg >> 20) & 7);
      f0 = fr(); p0 = po(); i0 = inf(); d0 = dn();
      case (op)
        0, 1: begin
          step(1, 0, (m_sp + k) & M, 0, 0);
          if (k <= f0) m_sp = (m_sp + k) & M; else m_err = 1;
        end
        2, 3: begin
          step(0, 0, 0, 1, 0);
          if (p0 != 0) m_hg = (m_hg + 1) & M;
        end
        4: begin
          step(0, 0, 0, 0, 1);
          if (i0 != 0) m_hp = (m_hp + 1) & M;
        end
        5: begin
          step(0, 0, 0, 1, 1);
          if (p0 != 0) m_hg = (m_hg + 1) & M;
          if (i0 != 0) m_hp = (m_hp + 1) & M;
        end
        6: begin
          step(1, 1, (m_sg + k) & M, 0, 0);
          if (k <= d0) m_sg = (m_sg + k) & M; else m_err = 1;
        end
        default: begin
          step(1, 3, 16'h0010, 0, 0);
          m_err = 0;
        end
      endcase
      check_all(0);
    end

    // R9 R10: stall timer corner cases
    do_reset();
    step(1, 2, 5, 0, 0);
    step(1, 0, 3, 0, 0);
    m_sp = 3;
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0);
    check_all(0);
    step(0, 0, 0, 0, 0);
    chk(stuck == 4'b0011, "R9 stuck after T+1 stalled edges", stuck, 3);
    step(1, 3, 1, 0, 0);
    chk(stuck == 4'b0011, "R10 set wins over clear", stuck, 3);
    step(1, 3, 2, 1, 0);
    m_hg = 1;
    chk(stuck == 4'b0001, "R10 clear after advance", stuck, 1);
    step(1, 2, 0, 0, 0);
    step(1, 3, 1, 0, 0);
    check_all(0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule